// File: doc/BRIEF.md
# Dual-Section Registered Bus Transceiver

This block passes data between an A-side bus and a B-side bus through storage registers. It is built from a parameterised number of independent byte-wide sections, two by default. Each section holds one register per direction. The A-to-B register loads the value seen on the A side, and the B-to-A register loads the value seen on the B side. A load happens on a rising edge of that direction's own clock, and only while that direction's active-low clock enable is low. A side is never driven straight from the other side's live input. Each side is driven from the register of the opposite direction, and only while that direction's active-low output enable is low.

Each bus side is split into three signals: data in, data out and a per-section drive enable. This keeps the block synthesizable. Any resolution onto shared nets happens outside the block. While a section drives its A side, the register that loads A data sees the driven value instead of the pin, so a load in that state copies the opposite register (loopback). The B side behaves the same way. Several sections can be given identical controls so that they act as one wider path.

Top module: `xcvr_dual_bank`

## Requirements
- R1: An active-low asynchronous reset `rst_ni` clears every direction register of every section to zero.
- R2: On a rising edge of a section's `clk_ab_i` bit while its `cken_ab_ni` bit is 0, the A-to-B register loads that section's effective A value.
- R3: A direction register keeps its value on a rising clock edge while its clock enable bit is 1, and it also keeps its value while no rising edge occurs, whatever its data input does.
- R4: While a section's `oe_ab_ni` bit is 0, its `b_oe_o` bit is 1 and its byte of `b_o` equals the A-to-B register. While that bit is 1, `b_oe_o` is 0 and the byte of `b_o` is 0.
- R5: The B-to-A direction follows R2 to R4 with `clk_ba_i`, `cken_ba_ni` and `oe_ba_ni`. It loads the effective B value and drives `a_o` and `a_oe_o`.
- R6: A load of one direction's register never changes the other direction's register in the same section.
- R7: Controls of one section never change the registers or outputs of another section. Identical controls on all sections make them act as one wide path.
- R8: The effective A value is the B-to-A register while `oe_ba_ni` is 0, and the `a_i` byte otherwise. The effective B value is the A-to-B register while `oe_ab_ni` is 0, and the `b_i` byte otherwise.
- R9: Both output enables of a section may be low together. In that state both sides drive their registers and nothing is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_ab_i | input | NUM_SECT | A-to-B load clock, one per section |
| cken_ab_ni | input | NUM_SECT | A-to-B clock enable, active low |
| oe_ab_ni | input | NUM_SECT | B-side drive enable, active low |
| clk_ba_i | input | NUM_SECT | B-to-A load clock, one per section |
| cken_ba_ni | input | NUM_SECT | B-to-A clock enable, active low |
| oe_ba_ni | input | NUM_SECT | A-side drive enable, active low |
| a_i | input | SECT_W*NUM_SECT | A-side pin value, section s in bits s*SECT_W upward |
| a_o | output | SECT_W*NUM_SECT | A-side drive data, zero where not driven |
| a_oe_o | output | NUM_SECT | A-side drive enable per section, active high |
| b_i | input | SECT_W*NUM_SECT | B-side pin value |
| b_o | output | SECT_W*NUM_SECT | B-side drive data, zero where not driven |
| b_oe_o | output | NUM_SECT | B-side drive enable per section, active high |

## Verification
The assertions check several rules at every clock edge of every section: the output gating and zeroing on both sides, the hold while the clock enable is high, and a load taking the effective value, including the loopback choice. Some behaviour only shows up in the bench's scenarios against its behavioural model. This covers the reset clearing both registers, a register staying unchanged while its data input moves without an edge, sections left untouched while a neighbour is clocked, and both sides driving at once.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  parameter int unsigned SECT_W   = 8;
  parameter int unsigned NUM_SECT = 2;
endpackage

// File: rtl/xcvr_stage_reg.sv
module xcvr_stage_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (!en_ni) q_o <= d_i;
  end
endmodule

// File: rtl/xcvr_port_drv.sv
// One bus side: gates the opposite register onto the pins and picks what the
// local register loads (driven value while driving, pin otherwise).
module xcvr_port_drv #(
  parameter int unsigned W = 8
) (
  input  logic         oe_ni,
  input  logic [W-1:0] q_i,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] data_o,
  output logic         drive_o,
  output logic [W-1:0] seen_o
);
  always_comb begin
    drive_o = !oe_ni;
    data_o  = oe_ni ? '0 : q_i;
    seen_o  = oe_ni ? pin_i : q_i;
  end
endmodule

// File: rtl/xcvr_section.sv
module xcvr_section #(
  parameter int unsigned W = 8
) (
  input  logic         rst_ni,
  input  logic         clk_ab_i,
  input  logic         cken_ab_ni,
  input  logic         oe_ab_ni,
  input  logic         clk_ba_i,
  input  logic         cken_ba_ni,
  input  logic         oe_ba_ni,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] a_o,
  output logic         a_oe_o,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] b_o,
  output logic         b_oe_o,
  output logic [W-1:0] ab_q_o,
  output logic [W-1:0] ba_q_o
);
  logic [W-1:0] a_seen, b_seen;

  xcvr_stage_reg #(.W(W)) u_ab_reg (
    .clk_i(clk_ab_i), .rst_ni(rst_ni), .en_ni(cken_ab_ni),
    .d_i(a_seen), .q_o(ab_q_o)
  );

  xcvr_stage_reg #(.W(W)) u_ba_reg (
    .clk_i(clk_ba_i), .rst_ni(rst_ni), .en_ni(cken_ba_ni),
    .d_i(b_seen), .q_o(ba_q_o)
  );

  xcvr_port_drv #(.W(W)) u_a_side (
    .oe_ni(oe_ba_ni), .q_i(ba_q_o), .pin_i(a_i),
    .data_o(a_o), .drive_o(a_oe_o), .seen_o(a_seen)
  );

  xcvr_port_drv #(.W(W)) u_b_side (
    .oe_ni(oe_ab_ni), .q_i(ab_q_o), .pin_i(b_i),
    .data_o(b_o), .drive_o(b_oe_o), .seen_o(b_seen)
  );
endmodule

// File: rtl/xcvr_dual_bank.sv
module xcvr_dual_bank
  import xcvr_pkg::*;
#(
  parameter int unsigned SECT_W   = xcvr_pkg::SECT_W,
  parameter int unsigned NUM_SECT = xcvr_pkg::NUM_SECT,
  localparam int unsigned BUS_W   = SECT_W * NUM_SECT
) (
  input  logic                rst_ni,
  input  logic [NUM_SECT-1:0] clk_ab_i,
  input  logic [NUM_SECT-1:0] cken_ab_ni,
  input  logic [NUM_SECT-1:0] oe_ab_ni,
  input  logic [NUM_SECT-1:0] clk_ba_i,
  input  logic [NUM_SECT-1:0] cken_ba_ni,
  input  logic [NUM_SECT-1:0] oe_ba_ni,
  input  logic [BUS_W-1:0]    a_i,
  output logic [BUS_W-1:0]    a_o,
  output logic [NUM_SECT-1:0] a_oe_o,
  input  logic [BUS_W-1:0]    b_i,
  output logic [BUS_W-1:0]    b_o,
  output logic [NUM_SECT-1:0] b_oe_o
);
  logic [BUS_W-1:0] ab_q, ba_q;

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    xcvr_section #(.W(SECT_W)) u_sect (
      .rst_ni    (rst_ni),
      .clk_ab_i  (clk_ab_i[s]),
      .cken_ab_ni(cken_ab_ni[s]),
      .oe_ab_ni  (oe_ab_ni[s]),
      .clk_ba_i  (clk_ba_i[s]),
      .cken_ba_ni(cken_ba_ni[s]),
      .oe_ba_ni  (oe_ba_ni[s]),
      .a_i       (a_i[s*SECT_W +: SECT_W]),
      .a_o       (a_o[s*SECT_W +: SECT_W]),
      .a_oe_o    (a_oe_o[s]),
      .b_i       (b_i[s*SECT_W +: SECT_W]),
      .b_o       (b_o[s*SECT_W +: SECT_W]),
      .b_oe_o    (b_oe_o[s]),
      .ab_q_o    (ab_q[s*SECT_W +: SECT_W]),
      .ba_q_o    (ba_q[s*SECT_W +: SECT_W])
    );
  end
endmodule

// File: rtl/xcvr_dual_bank_chk.sv
module xcvr_dual_bank_chk #(
  parameter int unsigned W = 8,
  parameter int unsigned N = 2
) (
  input logic           rst_ni,
  input logic [N-1:0]   clk_ab_i,
  input logic [N-1:0]   cken_ab_ni,
  input logic [N-1:0]   oe_ab_ni,
  input logic [N-1:0]   clk_ba_i,
  input logic [N-1:0]   cken_ba_ni,
  input logic [N-1:0]   oe_ba_ni,
  input logic [W*N-1:0] a_i,
  input logic [W*N-1:0] a_o,
  input logic [N-1:0]   a_oe_o,
  input logic [W*N-1:0] b_i,
  input logic [W*N-1:0] b_o,
  input logic [N-1:0]   b_oe_o,
  input logic [W*N-1:0] ab_q,
  input logic [W*N-1:0] ba_q
);
  for (genvar s = 0; s < N; s++) begin : g_chk
    p_b_drive_r4: assert property (@(posedge clk_ba_i[s]) disable iff (!rst_ni)
      !oe_ab_ni[s] |-> (b_oe_o[s] && b_o[s*W +: W] == ab_q[s*W +: W]));
    p_b_quiet_r4: assert property (@(posedge clk_ba_i[s]) disable iff (!rst_ni)
      oe_ab_ni[s] |-> (!b_oe_o[s] && b_o[s*W +: W] == '0));
    p_a_drive_r5: assert property (@(posedge clk_ab_i[s]) disable iff (!rst_ni)
      !oe_ba_ni[s] |-> (a_oe_o[s] && a_o[s*W +: W] == ba_q[s*W +: W]));
    p_a_quiet_r5: assert property (@(posedge clk_ab_i[s]) disable iff (!rst_ni)
      oe_ba_ni[s] |-> (!a_oe_o[s] && a_o[s*W +: W] == '0));
    p_ab_hold_r3: assert property (@(posedge clk_ab_i[s]) disable iff (!rst_ni)
      cken_ab_ni[s] |=> $stable(ab_q[s*W +: W]));
    p_ba_hold_r3: assert property (@(posedge clk_ba_i[s]) disable iff (!rst_ni)
      cken_ba_ni[s] |=> $stable(ba_q[s*W +: W]));
    // R8: the load source follows the opposite side's drive state
    p_ab_load_r2: assert property (@(posedge clk_ab_i[s]) disable iff (!rst_ni)
      !cken_ab_ni[s] |=> ab_q[s*W +: W] ==
        $past(oe_ba_ni[s] ? a_i[s*W +: W] : ba_q[s*W +: W]));
    p_ba_load_r5: assert property (@(posedge clk_ba_i[s]) disable iff (!rst_ni)
      !cken_ba_ni[s] |=> ba_q[s*W +: W] ==
        $past(oe_ab_ni[s] ? b_i[s*W +: W] : ab_q[s*W +: W]));
  end
endmodule

bind xcvr_dual_bank xcvr_dual_bank_chk #(.W(SECT_W), .N(NUM_SECT)) u_chk (
  .rst_ni(rst_ni), .clk_ab_i(clk_ab_i), .cken_ab_ni(cken_ab_ni),
  .oe_ab_ni(oe_ab_ni), .clk_ba_i(clk_ba_i), .cken_ba_ni(cken_ba_ni),
  .oe_ba_ni(oe_ba_ni), .a_i(a_i), .a_o(a_o), .a_oe_o(a_oe_o),
  .b_i(b_i), .b_o(b_o), .b_oe_o(b_oe_o), .ab_q(ab_q), .ba_q(ba_q)
);

// File: tb/xcvr_dual_bank_bench.sv
module xcvr_dual_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int N = 2;

  logic         rst_ni;
  logic [N-1:0] clk_ab, cken_ab_n, oe_ab_n, clk_ba, cken_ba_n, oe_ba_n;
  logic [W*N-1:0] a_in, b_in, a_out, b_out;
  logic [N-1:0] a_oe, b_oe;

  int n_vec = 0;
  int n_bad = 0;
  logic [W-1:0] m_ab [N];
  logic [W-1:0] m_ba [N];

  xcvr_dual_bank #(.SECT_W(W), .NUM_SECT(N)) u_xcvr_dual_bank (
    .rst_ni(rst_ni), .clk_ab_i(clk_ab), .cken_ab_ni(cken_ab_n), .oe_ab_ni(oe_ab_n),
    .clk_ba_i(clk_ba), .cken_ba_ni(cken_ba_n), .oe_ba_ni(oe_ba_n),
    .a_i(a_in), .a_o(a_out), .a_oe_o(a_oe),
    .b_i(b_in), .b_o(b_out), .b_oe_o(b_oe)
  );

  task automatic check(input string tag, input int s, input string what,
                       input logic [W:0] act, input logic [W:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s sect %0d %s: actual %h expected %h", tag, s, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    for (int s = 0; s < N; s++) begin
      check(tag, s, "b side", {b_oe[s], b_out[s*W +: W]},
            oe_ab_n[s] ? {1'b0, {W{1'b0}}} : {1'b1, m_ab[s]});
      check(tag, s, "a side", {a_oe[s], a_out[s*W +: W]},
            oe_ba_n[s] ? {1'b0, {W{1'b0}}} : {1'b1, m_ba[s]});
    end
  endtask

  // inputs already set by caller; pulse selected clocks, update model, compare
  task automatic step(input string tag, input logic [N-1:0] pab, input logic [N-1:0] pba);
    logic [W-1:0] nab [N];
    logic [W-1:0] nba [N];
    #(CLK_PERIOD/2);
    for (int s = 0; s < N; s++) begin
      nab[s] = m_ab[s];
      nba[s] = m_ba[s];
      if (pab[s] && !cken_ab_n[s]) nab[s] = oe_ba_n[s] ? a_in[s*W +: W] : m_ba[s];
      if (pba[s] && !cken_ba_n[s]) nba[s] = oe_ab_n[s] ? b_in[s*W +: W] : m_ab[s];
    end
    clk_ab = pab;
    clk_ba = pba;
    for (int s = 0; s < N; s++) begin
      m_ab[s] = nab[s];
      m_ba[s] = nba[s];
    end
    #(CLK_PERIOD/2);
    clk_ab = '0;
    clk_ba = '0;
    #1;
    compare(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    clk_ab = '0; clk_ba = '0;
    cken_ab_n = '1; cken_ba_n = '1;
    oe_ab_n = '1; oe_ba_n = '1;
    a_in = 16'h1234; b_in = 16'h5678;
    for (int s = 0; s < N; s++) begin m_ab[s] = '0; m_ba[s] = '0; end
    #(CLK_PERIOD*2);
    rst_ni = 1'b1;
    #(CLK_PERIOD);

    // R1: both registers read zero after reset; R9 both sides driving at once
    oe_ab_n = '0; oe_ba_n = '0;
    step("R1", '0, '0);
    step("R9", '0, '0);

    // R2: A-to-B load, different values per section, R7
    oe_ab_n = '0; oe_ba_n = '1; cken_ab_n = '0;
    a_in = 16'hC3A5;
    step("R2", 2'b11, 2'b00);
    a_in = 16'h7E00;
    step("R7", 2'b01, 2'b00);

    // R3: enable high blocks a load; no edge means no load
    cken_ab_n = '1; a_in = 16'hFFFF;
    step("R3", 2'b11, 2'b00);
    cken_ab_n = '0; a_in = 16'h0F0F;
    step("R3", 2'b00, 2'b00);

    // R4: B side released, then restored with register intact
    oe_ab_n = '1;
    step("R4", 2'b00, 2'b00);
    oe_ab_n = '0;
    step("R4", 2'b00, 2'b00);

    // R5: B-to-A load with A side driving; R6 A-to-B register untouched
    oe_ab_n = '1; oe_ba_n = '0; cken_ba_n = '0; cken_ab_n = '1;
    b_in = 16'h9A3C;
    step("R5", 2'b00, 2'b11);
    oe_ab_n = '0;
    step("R6", 2'b00, 2'b00);
    cken_ba_n = 2'b01; b_in = 16'h1111;
    oe_ab_n = '1;
    step("R5", 2'b00, 2'b11);

    // R8: loopback on both sides
    oe_ba_n = '0; cken_ab_n = '0; a_in = 16'hDEAD;
    step("R8", 2'b11, 2'b00);
    oe_ab_n = '0; oe_ba_n = '1; cken_ba_n = '0; cken_ab_n = '1; b_in = 16'hBEEF;
    step("R8", 2'b00, 2'b11);
    oe_ba_n = '0;
    step("R8", 2'b00, 2'b00);

    // R6: simultaneous loads in both directions use pre-edge values
    oe_ab_n = '1; oe_ba_n = '1; cken_ab_n = '0; cken_ba_n = '0;
    a_in = 16'h4455; b_in = 16'h6677;
    step("R6", 2'b11, 2'b11);
    oe_ab_n = '0; oe_ba_n = '0;
    step("R9", 2'b00, 2'b00);

    // R7: section 1 only, section 0 unchanged
    oe_ab_n = '1; oe_ba_n = '1; a_in = 16'hA1A2; b_in = 16'hB1B2;
    step("R7", 2'b10, 2'b10);
    oe_ab_n = '0; oe_ba_n = '0;
    step("R7", 2'b00, 2'b00);

    // R7: common controls act as one 16-bit path
    for (int k = 0; k < 4; k++) begin
      oe_ab_n = '0; oe_ba_n = '1; cken_ab_n = '0; cken_ba_n = '1;
      a_in = 16'h1357 * (k + 3);
      step("R7", '1, '0);
      oe_ab_n = '1; oe_ba_n = '0; cken_ba_n = '0; cken_ab_n = '1;
      b_in = 16'h2468 ^ (16'h0101 << k);
      step("R2", '0, '1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule